// File: doc/BRIEF.md
# Serial CRC-15 Frame Check Generator

This block computes the 15-bit cyclic redundancy check that closes a vehicle-bus data frame. Bits arrive one per qualified clock cycle, most significant bit of each byte first. A start pulse opens a frame and loads the register with all ones. Every qualified bit then advances a linear feedback register built on the polynomial x^15 + x^11 + x^10 + x^9 + x^8 + x^7 + x^4 + x^3 + x^2 + 1. A finish pulse closes the frame and inverts the register.

The inverted 15-bit value is moved up one place, so that a zero end-of-data delimiter takes bit 0 of a 16-bit word. That word is held on a parallel output. A one-cycle done pulse marks the moment it becomes valid. The same word is also shifted out serially, one bit per clock, starting with bit 15. The check bits therefore leave the block in line order and are followed by the zero delimiter.

Line coding, bit timing, arbitration and acknowledge handling are left to the surrounding logic.

Top module: `crc15_fcs_gen`

## Requirements
- R1: After reset, `chk_word_o` is 0x0000, and `done_o`, `ser_vld_o` and `ser_bit_o` are all low.
- R2: The register is preset to 0x7FFF. Each bit is combined as fb = bit XOR reg[14], then reg = (reg << 1) masked to 15 bits, XOR 0x0F9D when fb is 1. At finish, the register is XORed with 0x7FFF. For the bytes 5E 4C 20 FF the check word is 0xF934, and for a frame with no data bits it is 0x0000.
- R3: `chk_word_o` is the 15-bit result placed in bits 15..1, and bit 0 is always 0.
- R4: A data bit is used only in a cycle where `bit_vld_i` is high. The value on `bit_i` in other cycles has no effect on the result.
- R5: `sof_i` presets the register. If `bit_vld_i` is high in the same cycle, that bit is taken as the first data bit of the new frame.
- R6: A valid bit presented in the same cycle as `fin_i` is included as the last data bit of the frame.
- R7: `done_o` is high for exactly one cycle, namely the cycle after a `fin_i` accepted on an open frame, and `chk_word_o` is valid from that cycle. The word then holds its value until the next `sof_i`.
- R8: `ser_vld_o` rises together with `done_o` and stays high for exactly 16 cycles. During those cycles `ser_bit_o` carries `chk_word_o` from bit 15 down to bit 0, so the last bit carried is the zero delimiter.
- R9: `sof_i` clears `chk_word_o` to 0x0000 one cycle later and stops any serial output that is in progress.
- R10: `fin_i` while no frame is open is ignored. No done pulse follows, and the word is left unchanged.
- R11: When `sof_i` and `fin_i` are high in the same cycle, the start wins. The frame is opened and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sof_i | input | 1 | Start-of-frame pulse; presets the check register |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Serial data bit, byte MSB first |
| fin_i | input | 1 | End-of-data pulse; closes the frame |
| chk_word_o | output | 16 | Packed check word, delimiter zero in bit 0 |
| done_o | output | 1 | One-cycle pulse when `chk_word_o` becomes valid |
| ser_vld_o | output | 1 | High while serial check bits are being sent |
| ser_bit_o | output | 1 | Serial check bit, bit 15 first |

## Verification
The bound checker watches several properties on every cycle:
- `done_o` appears only after a finish that was not overridden by a start, and never lasts more than one cycle.
- Bit 0 of the word stays zero.
- The word changes only on a done pulse or after a start, and a start leaves it cleared.
- The serial burst begins together with done, lasts 16 cycles and ends on a zero bit.

The arithmetic itself can only be shown by the bench's scenarios. These compare the word against an independently computed checksum, including the known frame, the empty frame, gapped bit strobes, and bits that coincide with the start and finish pulses. The bench scenarios also cover the ignored finish and the start/finish collision.

// File: rtl/crc15_pkg.sv
package crc15_pkg;

  // Check register width and the arithmetic constants of the frame check
  localparam int unsigned CRC_W = 15;
  localparam logic [CRC_W-1:0] CRC_POLY   = 15'h0F9D;
  localparam logic [CRC_W-1:0] CRC_PRESET = 15'h7FFF;
  localparam logic [CRC_W-1:0] CRC_XOROUT = 15'h7FFF;

  // Frame tracking state of the accumulator
  typedef enum logic {
    FR_CLOSED = 1'b0,
    FR_OPEN   = 1'b1
  } frame_e;

endpackage

// File: rtl/crc15_rst_sync.sv
module crc15_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift a one in from the bottom; assertion is immediate, release waits
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[LAST];

endmodule

// File: rtl/crc15_lfsr_step.sv
module crc15_lfsr_step #(
  parameter int unsigned   W    = 15,
  parameter logic [W-1:0]  POLY = '0
) (
  input  logic [W-1:0] crc_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);

  localparam int unsigned TOP = W - 1;

  logic fb;

  // Feedback is the incoming bit against the outgoing top bit
  assign fb = bit_i ^ crc_i[TOP];

  // One tap per register bit; the polynomial picks where feedback lands
  for (genvar i = 0; i < W; i++) begin : gen_tap
    if (i == 0) begin : gen_lsb
      assign crc_o[i] = fb & POLY[i];
    end else begin : gen_upper
      assign crc_o[i] = crc_i[i-1] ^ (fb & POLY[i]);
    end
  end

endmodule

// File: rtl/crc15_accum.sv
module crc15_accum
  import crc15_pkg::*;
#(
  parameter int unsigned  W      = 15,
  parameter logic [W-1:0] POLY   = '0,
  parameter logic [W-1:0] PRESET = '1,
  parameter logic [W-1:0] XOROUT = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sof_i,
  input  logic         bit_vld_i,
  input  logic         bit_i,
  input  logic         fin_i,
  output logic [W:0]   word_o,
  output logic         done_o,
  output logic         load_o,
  output logic [W:0]   load_word_o
);

  localparam int unsigned WORD_W = W + 1;

  frame_e             st_q, st_d;
  logic [W-1:0]       crc_q, crc_d;
  logic [WORD_W-1:0]  word_q, word_d;
  logic               done_q, done_d;
  logic               en;
  logic               take;
  logic [W-1:0]       step_base;
  logic [W-1:0]       stepped;
  logic [W-1:0]       tail;

  // A start presets before the bit of the same cycle is applied
  assign step_base = sof_i ? PRESET : crc_q;

  crc15_lfsr_step #(
    .W    (W),
    .POLY (POLY)
  ) u_step (
    .crc_i (step_base),
    .bit_i (bit_i),
    .crc_o (stepped)
  );

  // Register content including a bit that arrives with the finish pulse
  assign tail = bit_vld_i ? stepped : crc_q;

  always_comb begin
    st_d   = st_q;
    crc_d  = crc_q;
    word_d = word_q;
    done_d = 1'b0;
    take   = 1'b0;
    if (sof_i) begin
      st_d   = FR_OPEN;
      word_d = '0;
      crc_d  = bit_vld_i ? stepped : PRESET;
    end else if (st_q == FR_OPEN) begin
      if (bit_vld_i) begin
        crc_d = stepped;
      end
      if (fin_i) begin
        st_d   = FR_CLOSED;
        word_d = {tail ^ XOROUT, 1'b0};
        done_d = 1'b1;
        take   = 1'b1;
      end
    end
  end

  // Clock enable: only a start or activity in an open frame moves state
  assign en = sof_i | ((st_q == FR_OPEN) & (bit_vld_i | fin_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_CLOSED;
      crc_q  <= PRESET;
      word_q <= '0;
    end else if (en) begin
      st_q   <= st_d;
      crc_q  <= crc_d;
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign word_o      = word_q;
  assign done_o      = done_q;
  assign load_o      = take;
  assign load_word_o = word_d;

endmodule

// File: rtl/crc15_serializer.sv
module crc15_serializer #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              abort_i,
  output logic              vld_o,
  output logic              bit_o
);

  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q, vld_d;
  logic              en;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    vld_d = vld_q;
    if (abort_i) begin
      sh_d  = '0;
      cnt_d = '0;
      vld_d = 1'b0;
    end else if (load_i) begin
      sh_d  = word_i;
      cnt_d = CNT_LAST;
      vld_d = 1'b1;
    end else if (vld_q) begin
      sh_d = {sh_q[WORD_W-2:0], 1'b0};
      if (cnt_q == '0) begin
        vld_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign en = abort_i | load_i | vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else if (en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign vld_o = vld_q;
  assign bit_o = sh_q[WORD_W-1] & vld_q;

endmodule

// File: rtl/crc15_fcs_gen.sv
module crc15_fcs_gen
  import crc15_pkg::*;
#(
  parameter int unsigned      W           = CRC_W,
  parameter logic [W-1:0]     POLY        = CRC_POLY,
  parameter logic [W-1:0]     PRESET      = CRC_PRESET,
  parameter logic [W-1:0]     XOROUT      = CRC_XOROUT,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sof_i,
  input  logic        bit_vld_i,
  input  logic        bit_i,
  input  logic        fin_i,
  output logic [15:0] chk_word_o,
  output logic        done_o,
  output logic        ser_vld_o,
  output logic        ser_bit_o
);

  localparam int unsigned WORD_W = W + 1;

  logic              rst_n_int;
  logic              load;
  logic [WORD_W-1:0] load_word;
  logic [WORD_W-1:0] word;

  crc15_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  crc15_accum #(
    .W      (W),
    .POLY   (POLY),
    .PRESET (PRESET),
    .XOROUT (XOROUT)
  ) u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .sof_i       (sof_i),
    .bit_vld_i   (bit_vld_i),
    .bit_i       (bit_i),
    .fin_i       (fin_i),
    .word_o      (word),
    .done_o      (done_o),
    .load_o      (load),
    .load_word_o (load_word)
  );

  crc15_serializer #(
    .WORD_W (WORD_W)
  ) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .load_i  (load),
    .word_i  (load_word),
    .abort_i (sof_i),
    .vld_o   (ser_vld_o),
    .bit_o   (ser_bit_o)
  );

  assign chk_word_o = word;

endmodule

// File: rtl/crc15_fcs_gen_chk.sv
module crc15_fcs_gen_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sof_i,
  input logic              fin_i,
  input logic [WORD_W-1:0] chk_word_o,
  input logic              done_o,
  input logic              ser_vld_o,
  input logic              ser_bit_o
);

  // Counts cycles of the current serial burst, the done cycle being the first
  logic [7:0] burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= '0;
    end else if (done_o) begin
      burst_q <= 8'd1;
    end else if (ser_vld_o) begin
      burst_q <= burst_q + 8'd1;
    end else begin
      burst_q <= '0;
    end
  end

  assert_done_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(fin_i) && !$past(sof_i)));

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_word_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$past(sof_i)) |-> $stable(chk_word_o));

  assert_delim_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_word_o[0] == 1'b0);

  assert_start_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sof_i) |-> (chk_word_o == '0 && !done_o && !ser_vld_o));

  assert_ser_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ser_vld_o && ser_bit_o == chk_word_o[WORD_W-1]));

  assert_ser_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_vld_o) |-> done_o);

  assert_ser_length_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ser_vld_o) && !$past(sof_i)) |-> (burst_q == 8'(WORD_W) && $past(ser_bit_o) == 1'b0));

endmodule

bind crc15_fcs_gen crc15_fcs_gen_chk #(
  .WORD_W (WORD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sof_i      (sof_i),
  .fin_i      (fin_i),
  .chk_word_o (chk_word_o),
  .done_o     (done_o),
  .ser_vld_o  (ser_vld_o),
  .ser_bit_o  (ser_bit_o)
);

// File: tb/crc15_fcs_gen_tb.sv
`timescale 1ns/1ps
module crc15_fcs_gen_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        sof_i, bit_vld_i, bit_i, fin_i;
  logic [15:0] chk_word_o;
  logic        done_o, ser_vld_o, ser_bit_o;

  int n_chk = 0;
  int n_bad = 0;
  logic stim [0:127];
  int   stim_n;

  always #2.5 clk_i = ~clk_i;

  crc15_fcs_gen u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .fin_i      (fin_i),
    .chk_word_o (chk_word_o),
    .done_o     (done_o),
    .ser_vld_o  (ser_vld_o),
    .ser_bit_o  (ser_bit_o)
  );

  // Independent reference: preset, per-bit division, final inversion, pack
  function automatic logic [15:0] ref_word(input int n);
    logic [14:0] r;
    logic fb;
    r = 15'h7FFF;
    for (int i = 0; i < n; i++) begin
      fb = stim[i] ^ r[14];
      r  = {r[13:0], 1'b0};
      if (fb) r = r ^ 15'h0F9D;
    end
    return {r ^ 15'h7FFF, 1'b0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle from a falling edge; return at the next falling edge
  task automatic cyc(input logic s, input logic v, input logic b, input logic f);
    sof_i = s; bit_vld_i = v; bit_i = b; fin_i = f;
    @(negedge clk_i);
    sof_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0; fin_i = 1'b0;
  endtask

  task automatic clear_stim();
    stim_n = 0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) begin
      stim[stim_n] = b[k];
      stim_n++;
    end
  endtask

  // Send the staged bits; gap inserts invalid cycles carrying a one
  task automatic run_frame(input bit gap, input bit merge_first, input bit merge_last);
    int i;
    int stop;
    i = 0;
    stop = merge_last ? stim_n - 1 : stim_n;
    if (merge_first) begin
      cyc(1'b1, 1'b1, stim[0], 1'b0);
      i = 1;
    end else begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
    end
    for (; i < stop; i++) begin
      if (gap && (i % 3 == 1)) cyc(1'b0, 1'b0, 1'b1, 1'b0);
      cyc(1'b0, 1'b1, stim[i], 1'b0);
    end
    if (merge_last) cyc(1'b0, 1'b1, stim[stim_n-1], 1'b1);
    else            cyc(1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    check("R1 word", 32'(chk_word_o), 32'h0);
    check("R1 done", 32'(done_o), 32'h0);
    check("R1 ser_vld", 32'(ser_vld_o), 32'h0);
    check("R1 ser_bit", 32'(ser_bit_o), 32'h0);
  endtask

  task automatic t_known();
    clear_stim();
    push_byte(8'h5E); push_byte(8'h4C); push_byte(8'h20); push_byte(8'hFF);
    run_frame(1'b0, 1'b0, 1'b0);
    check("R2 known frame", 32'(chk_word_o), 32'hF934);
    check("R2 model agrees", 32'(chk_word_o), 32'(ref_word(stim_n)));
    check("R3 delimiter bit", 32'(chk_word_o[0]), 32'h0);
    check("R7 done on word", 32'(done_o), 32'h1);
  endtask

  task automatic t_done_hold();
    logic [15:0] w;
    w = chk_word_o;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 done one cycle", 32'(done_o), 32'h0);
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
    check("R7 word held", 32'(chk_word_o), 32'(w));
  endtask

  task automatic t_gaps();
    clear_stim();
    push_byte(8'hA5); push_byte(8'h3C); push_byte(8'h0F); push_byte(8'h81); push_byte(8'h19);
    run_frame(1'b1, 1'b0, 1'b0);
    check("R4 gapped strobes", 32'(chk_word_o), 32'(ref_word(stim_n)));
  endtask

  task automatic t_merge();
    clear_stim();
    push_byte(8'h12); push_byte(8'h34); push_byte(8'h56);
    run_frame(1'b0, 1'b1, 1'b0);
    check("R5 bit with start", 32'(chk_word_o), 32'(ref_word(stim_n)));
    clear_stim();
    push_byte(8'hC3); push_byte(8'h7E);
    run_frame(1'b0, 1'b0, 1'b1);
    check("R6 bit with finish", 32'(chk_word_o), 32'(ref_word(stim_n)));
    check("R6 done", 32'(done_o), 32'h1);
  endtask

  task automatic t_serial();
    logic [15:0] w;
    logic [15:0] got;
    int vcnt;
    clear_stim();
    push_byte(8'hE7); push_byte(8'h01); push_byte(8'h9B);
    run_frame(1'b0, 1'b0, 1'b0);
    w = chk_word_o;
    check("R8 serial word", 32'(w), 32'(ref_word(stim_n)));
    vcnt = 0;
    got = '0;
    for (int k = 15; k >= 0; k--) begin
      if (ser_vld_o) vcnt++;
      got[k] = ser_bit_o;
      if (k != 0) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    end
    check("R8 serial bits msb first", 32'(got), 32'(w));
    check("R8 delimiter last", 32'(got[0]), 32'h0);
    check("R8 valid cycles", 32'(vcnt), 32'd16);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 valid drops", 32'(ser_vld_o), 32'h0);
  endtask

  task automatic t_sof_clear();
    clear_stim();
    push_byte(8'h55);
    run_frame(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0);
    check("R9 word cleared", 32'(chk_word_o), 32'h0);
    check("R9 serial aborted", 32'(ser_vld_o), 32'h0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R2 empty frame", 32'(chk_word_o), 32'h0);
    check("R2 empty frame done", 32'(done_o), 32'h1);
  endtask

  task automatic t_fin_closed();
    logic [15:0] w;
    clear_stim();
    push_byte(8'h3A);
    run_frame(1'b0, 1'b0, 1'b0);
    w = chk_word_o;
    for (int k = 0; k < 17; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1, 1'b1);
    check("R10 no done when closed", 32'(done_o), 32'h0);
    check("R10 word kept", 32'(chk_word_o), 32'(w));
    check("R10 no serial", 32'(ser_vld_o), 32'h0);
  endtask

  task automatic t_sof_fin_same();
    clear_stim();
    push_byte(8'h9C);
    cyc(1'b1, 1'b0, 1'b0, 1'b1);
    check("R11 no done", 32'(done_o), 32'h0);
    check("R11 word cleared", 32'(chk_word_o), 32'h0);
    for (int i = 0; i < stim_n; i++) cyc(1'b0, 1'b1, stim[i], 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1);
    check("R11 frame stayed open", 32'(chk_word_o), 32'(ref_word(stim_n)));
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    sof_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0; fin_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_known();
    t_done_hold();
    t_gaps();
    t_merge();
    t_serial();
    t_sof_clear();
    t_fin_closed();
    t_sof_fin_same();
    repeat (20) @(negedge clk_i);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule